// File: doc/BRIEF.md
# Complex Q1.15 Narrowing Stage

This block takes a stream of complex samples whose real and imaginary parts are each a signed 25-bit value with 23 fractional bits. It turns each part into signed Q1.15 (16 bits, 15 of them fractional) and packs the two results into one 32-bit word. A sample shrinks from 50 bits to 32, which lowers the bandwidth and buffer space needed further down the stream.

Each part is narrowed by dropping eight low bits with round-half-up. Because the input carries one more integer bit than Q1.15, a rounded value can fall outside the output range. Such a value is clamped rather than wrapped. A sticky flag records that clamping happened, and a plain clear pin resets it.

Both the input and the output use a valid/ready handshake. A transfer takes place on a rising clock edge where valid and ready are both high. While a word is waiting, the block holds `out_valid` and `out_word` steady until `out_ready` accepts it. The input side holds `in_ready` low only when both internal stages are full and the output is stalled. The producer must keep `in_valid` and the input data steady until a transfer happens.

Top module: `cplx_q15_narrow`

## Requirements
- R1: After reset, `out_valid` and `sat_flag` are 0 and `in_ready` is 1.
- R2: Each part is rounded half-up. The block adds 128 to the 25-bit two's-complement value, then shifts it right by 8 bits, keeping the sign. An exact half therefore rounds toward positive infinity (0x80 gives 1, and -0x80 gives 0).
- R3: A rounded part above 32767 is output as 0x7FFF.
- R4: A rounded part below -32768 is output as 0x8000.
- R5: `out_word[31:16]` holds the real part and `out_word[15:0]` holds the imaginary part, both in two's complement.
- R6: A sample accepted at clock edge k appears on the output after edge k+1 (two register stages).
- R7: When `out_ready` is high, `in_ready` is high, so the block accepts one sample on every clock with no gaps.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_word` keep their values. Once both stages are full, `in_ready` goes low.
- R9: `sat_flag` is set when a sample with at least one clamped part enters the output stage. It stays set until it is cleared.
- R10: A high `sat_clear` resets `sat_flag` on the next edge. If a new clamp event arrives on that same edge, the set wins.
- R11: Samples leave in the order they entered, with no loss and no duplicates, under any back-pressure pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_re | input | 25 | Real part, signed, 23 fractional bits |
| in_im | input | 25 | Imaginary part, signed, 23 fractional bits |
| out_valid | output | 1 | Packed word present |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 32 | Packed Q1.15 real (high half) and imaginary (low half) |
| sat_clear | input | 1 | Clears the clamp flag |
| sat_flag | output | 1 | Sticky record of any clamped part |

## Verification
The first set of directed values sits around the rounding point: exact ties of each sign, and values just above and below a tie. These show whether the block rounds half-up, truncates, or rounds half away from zero. A second set sits at the range edges: 0x7FFF7F and 0x7FFF80, exactly -1.0, one step below -1.0, and full scale of each sign. These show the difference between clamping and wrapping, and check that the flag rises only when a value is actually clamped. Real and imaginary parts are always given different values, so a swapped packing is caught. A long stream of random values under random back-pressure, plus one run with the output fully stalled, shows whether words are held, lost, duplicated or reordered.

// File: rtl/cq_pkg.sv
package cq_pkg;
  parameter int IN_W     = 25;
  parameter int IN_FRAC  = 23;
  parameter int OUT_W    = 16;
  parameter int OUT_FRAC = 15;
  parameter int N_COMP   = 2;

  localparam int DROP   = IN_FRAC - OUT_FRAC;
  localparam int MID_W  = IN_W + 1 - DROP;
  localparam int WORD_W = N_COMP * OUT_W;

  typedef logic signed [IN_W-1:0]  wide_t;
  typedef logic signed [MID_W-1:0] mid_t;
  typedef logic signed [OUT_W-1:0] q_t;
endpackage

// File: rtl/cq_round.sv
module cq_round
  import cq_pkg::*;
(
  input  wide_t din,
  output mid_t  dout
);
  localparam logic [IN_W:0] HALF = (IN_W+1)'(1) << (DROP - 1);

  logic [IN_W:0] biased;

  // widen by one bit so the bias never wraps
  assign biased = {din[IN_W-1], din} + HALF;
  assign dout   = mid_t'(biased[IN_W:DROP]);
endmodule

// File: rtl/cq_sat.sv
module cq_sat
  import cq_pkg::*;
(
  input  mid_t din,
  output q_t   dout,
  output logic clamped
);
  localparam int TOP_W = MID_W - OUT_W + 1;

  logic [TOP_W-1:0] top_bits;
  logic             fits;

  assign top_bits = din[MID_W-1:OUT_W-1];
  assign fits     = (&top_bits) | (~|top_bits);
  assign clamped  = ~fits;

  always_comb begin
    if (fits)
      dout = din[OUT_W-1:0];
    else if (din[MID_W-1])
      dout = {1'b1, {(OUT_W-1){1'b0}}};
    else
      dout = {1'b0, {(OUT_W-1){1'b1}}};
  end
endmodule

// File: rtl/cq_stage.sv
module cq_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = ~dn_valid | dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dn_valid <= 1'b0;
    else if (up_ready) dn_valid <= up_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dn_data <= '0;
    else if (up_ready && up_valid) dn_data <= up_data;
  end

  // R11
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));
endmodule

// File: rtl/cplx_q15_narrow.sv
module cplx_q15_narrow
  import cq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IN_W-1:0]      in_re,
  input  logic [IN_W-1:0]      in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_W-1:0]    out_word,
  input  logic                 sat_clear,
  output logic                 sat_flag
);
  localparam int MID_BUS = N_COMP * MID_W;

  wide_t                comp_in [N_COMP];
  logic [MID_BUS-1:0]   mid_bus_in, mid_bus_s1;
  logic [WORD_W-1:0]    q_bus;
  logic [N_COMP-1:0]    comp_clamp;
  logic                 s1_valid, s1_ready;
  logic                 load_out, sat_any;

  // component 0 is real (upper), component 1 is imaginary (lower)
  assign comp_in[0] = wide_t'(in_re);
  assign comp_in[1] = wide_t'(in_im);

  for (genvar c = 0; c < N_COMP; c++) begin : g_round
    mid_t rnd;
    cq_round u_rnd (.din(comp_in[c]), .dout(rnd));
    assign mid_bus_in[(N_COMP-1-c)*MID_W +: MID_W] = rnd;
  end

  cq_stage #(.W(MID_BUS)) u_s1 (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(mid_bus_in),
    .dn_valid(s1_valid), .dn_ready(s1_ready), .dn_data(mid_bus_s1)
  );

  for (genvar c = 0; c < N_COMP; c++) begin : g_sat
    q_t q;
    cq_sat u_sat (
      .din(mid_t'(mid_bus_s1[c*MID_W +: MID_W])),
      .dout(q),
      .clamped(comp_clamp[c])
    );
    assign q_bus[c*OUT_W +: OUT_W] = q;
  end

  cq_stage #(.W(WORD_W)) u_s2 (
    .clk(clk), .rst_n(rst_n),
    .up_valid(s1_valid), .up_ready(s1_ready), .up_data(q_bus),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(out_word)
  );

  assign load_out = s1_valid & s1_ready;
  assign sat_any  = |comp_clamp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sat_flag <= 1'b0;
    else if (load_out && sat_any)  sat_flag <= 1'b1;
    else if (sat_clear)            sat_flag <= 1'b0;
  end

  // R7
  ready_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && s1_valid && !out_ready |-> !in_ready);

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_out && sat_any |=> sat_flag);

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clear |=> sat_flag);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clear && !(load_out && sat_any) |=> !sat_flag);
endmodule

// File: tb/cplx_q15_narrow_test.sv
`timescale 1ns/1ps
module cplx_q15_narrow_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [24:0] in_re = '0, in_im = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_word;
  logic        sat_clear = 1'b0;
  logic        sat_flag;

  int n_checks = 0, n_fail = 0;
  int bp_mode = 0;      // 0 always ready, 1 random, 2 stalled
  int wait_cycles = 0;
  logic [31:0] exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  cplx_q15_narrow uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .sat_clear(sat_clear), .sat_flag(sat_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int rnd_part(input int v);
    return (v + 128) >>> 8;
  endfunction

  function automatic logic [15:0] ref_q(input int v);
    int r = rnd_part(v);
    if (r > 32767)  return 16'h7fff;
    if (r < -32768) return 16'h8000;
    return 16'(r);
  endfunction

  function automatic bit ref_clamp(input int v);
    int r = rnd_part(v);
    return (r > 32767) || (r < -32768);
  endfunction

  // out_ready driver
  initial forever begin
    @(negedge clk);
    out_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? 1'($urandom % 2) : 1'b0;
  end

  // driver: present sample, wait for acceptance, push expected word
  task automatic drive(input int re, input int im);
    @(negedge clk);
    in_valid = 1'b1;
    in_re = 25'(re);
    in_im = 25'(im);
    #1;
    while (!in_ready) begin
      wait_cycles++;
      @(negedge clk);
      #1;
    end
    exp_q.push_back({ref_q(re), ref_q(im)});
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare every accepted output word (R2 R3 R4 R5 R11)
  initial forever begin
    @(negedge clk);
    #2;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R11 unexpected word", out_word, 32'hxxxxxxxx);
      else check("R2/R3/R4/R5/R11 word", out_word, exp_q.pop_front());
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    #1;
    // R1
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 sat_flag", 32'(sat_flag), 0);
    check("R1 in_ready", 32'(in_ready), 1);
    rst_n = 1'b1;

    // R6 latency
    drive(32'h000100, -32'h000200);
    @(negedge clk); in_valid = 1'b0; #3;
    check("R6 not yet valid", 32'(out_valid), 0);
    @(negedge clk); #3;
    check("R6 valid after second edge", 32'(out_valid), 1);
    check("R5 packing", out_word, {16'h0001, 16'hfffe});
    idle(3);

    // R2 rounding ties and neighbours
    drive(32'h80, -32'h80);
    drive(32'h7f, -32'h81);
    drive(32'h180, -32'h180);
    drive(32'h17f, 32'h181);
    drive(32'h7fff7f, -32'h800000);
    drive(0, 32'h123456);
    idle(5);
    check("R9 no clamp keeps flag low", 32'(sat_flag), 0);

    // R3 R4 clamping
    drive(32'h7fff80, 0);
    idle(5);
    check("R9 flag after positive clamp", 32'(sat_flag), 1);
    sat_clear = 1'b1; @(negedge clk); sat_clear = 1'b0; #1;
    check("R10 cleared", 32'(sat_flag), 0);
    drive(0, -32'h800081);
    drive(32'hffffff, -32'h1000000);
    drive(-32'h1000000, 32'hffffff);
    idle(5);
    check("R9 flag after negative clamp", 32'(sat_flag), 1);
    idle(4);
    check("R9 flag sticky", 32'(sat_flag), 1);
    sat_clear = 1'b1; @(negedge clk); sat_clear = 1'b0; #1;
    check("R10 cleared again", 32'(sat_flag), 0);

    // R8 stall
    bp_mode = 2;
    idle(1);
    drive(32'h4000, 32'h8000);
    drive(32'h10000, -32'h10000);
    @(negedge clk);
    in_valid = 1'b1; in_re = 25'h2000; in_im = 25'h3000;
    #1;
    check("R8 in_ready low when full", 32'(in_ready), 0);
    held = out_word;
    repeat (3) @(negedge clk);
    #1;
    check("R8 out_valid held", 32'(out_valid), 1);
    check("R8 out_word held", out_word, held);
    bp_mode = 0;
    drive(32'h2000, 32'h3000);

    // R7 full throughput
    wait_cycles = 0;
    for (int i = 0; i < 20; i++) drive(i * 977, -i * 1313);
    check("R7 no input wait while ready", 32'(wait_cycles), 0);

    // R11 random stream under random back-pressure
    bp_mode = 1;
    for (int i = 0; i < 400; i++) begin
      int a = int'($urandom % 33554432) - 16777216;
      int b = int'($urandom % 33554432) - 16777216;
      drive(a, b);
      if (i % 37 == 0) idle(2);
    end
    bp_mode = 0;
    idle(10);
    check("R11 all words delivered", 32'(exp_q.size()), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule